// File: doc/BRIEF.md
# Oversampling UART Baud Generator

This block derives every timing pulse a UART needs from one functional clock. A prescaler divides that clock by a 13-bit divisor and yields the oversample tick. A phase counter then groups those ticks into bit periods of a programmable oversampling ratio. It emits a bit tick on the last clock of every period and a sample strobe near the middle of each period, where the receiver samples the line. The resulting bit rate is the clock frequency divided by the product of the divisor and the ratio. For example, a 24 MHz clock with a divisor of 26 and a ratio of 8 gives a bit period of 208 clocks, which is about 115384 bit/s.

The configuration is three fields: the divisor, the ratio field (the ratio minus one), and a both-edge request. The block copies these into shadow registers only while `enable` is low, so a running bit period never sees a half-written setting. In both-edge mode the phase counter advances on two events per divisor period, one at the middle of the divisor count and one at its end. This halves the step between candidate sample points and matters most at the low ratios. A one-cycle `resync` pulse, raised by the receiver when it sees a start edge, restarts the divisor and the bit period from zero.

Top module: `baud_gen`

## Requirements
- R1: While enabled with a nonzero divisor D and effective ratio N, `bit_tick` pulses on the last cycle of every period of D×N clocks. Cycle 0 is the first enabled cycle (or the first cycle after `resync`), so the pulses fall at cycles D×N−1, 2×D×N−1, and so on.
- R2: When both-edge is not in effect, `os_tick` pulses on cycles k where k mod D equals D−1.
- R3: The effective ratio is the 5-bit field value plus one. Field values 0, 1 and 2 are treated as a ratio of 4, so N always lies between 4 and 32.
- R4: A divisor of zero stops all generation. `os_tick`, `bit_tick` and `sample_strobe` stay low.
- R5: In both-edge mode with D ≥ 2, `os_tick` also pulses on cycles where k mod D equals floor(D/2)−1. With D = 1 it pulses only once per clock, on the divisor end.
- R6: Both-edge mode is in effect whenever the effective ratio is below 8, whatever the both-edge request says. At ratios of 8 and above it follows the request.
- R7: `sample_strobe` pulses once per bit period, at offset k mod (D×N). In both-edge mode with D ≥ 2 and an odd N, the offset is ((N−1)/2)×D + floor(D/2) − 1. In every other case it is ceil(N/2)×D − 1.
- R8: During a cycle with `resync` high, all three outputs are low. The next cycle is cycle 0 of a fresh bit period.
- R9: The divisor, ratio field and both-edge request are captured only on clock edges where `enable` is low. Changes made while enabled have no effect on the outputs.
- R10: While `enable` is low, all outputs are low. Enabling again restarts counting at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; while low, configuration is captured |
| resync | input | 1 | One-cycle pulse that restarts the bit period |
| div_in | input | 13 | Modulo divisor; 0 disables generation |
| ratio_field | input | 5 | Oversampling ratio minus one |
| both_edge_in | input | 1 | Requests both-edge sampling |
| os_tick | output | 1 | Oversample tick |
| bit_tick | output | 1 | Last cycle of each bit period |
| sample_strobe | output | 1 | Mid-bit sample point |

## Verification
The generator is run under randomly drawn divisors, ratio fields and both-edge requests. Each setting runs for at least two full bit periods and is compared every cycle against a clock-count model, so odd ratios separate the half-tick midpoint from the whole-tick midpoint and even ratios confirm the two agree.

Directed settings cover the following cases:
- The 26-by-8 case.
- A divisor of one with both-edge requested, where no half point exists.
- The largest divisor.
- A zero divisor.
- A clamped ratio field.

Separate runs change the fields mid-period and pulse `resync` mid-period. These tell a shadowed configuration apart from a live one, and a true restart apart from a counter that merely continues.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int DIV_W      = 13;
  localparam int FIELD_W    = 5;
  localparam int RATIO_W    = FIELD_W + 1;
  localparam int MIN_RATIO  = 4;
  localparam int BE_BELOW   = 8;

  // Effective oversampling ratio from the stored ratio-minus-one field.
  function automatic logic [RATIO_W-1:0] eff_ratio(input logic [FIELD_W-1:0] field);
    logic [RATIO_W-1:0] r;
    r = {1'b0, field} + RATIO_W'(1);
    if (r < RATIO_W'(MIN_RATIO)) r = RATIO_W'(MIN_RATIO);
    return r;
  endfunction

  // Both-edge mode is forced for the low ratios.
  function automatic logic eff_both(input logic req, input logic [RATIO_W-1:0] r);
    return req | (r < RATIO_W'(BE_BELOW));
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         run,
  input  logic [W-1:0] div,
  output logic         full_ev,
  output logic         half_ev
);
  logic [W-1:0] cnt;
  logic [W-1:0] last_pos;
  logic [W-1:0] half_pos;
  logic         splittable;

  assign last_pos   = div - W'(1);
  assign half_pos   = (div >> 1) - W'(1);
  assign splittable = (div >= W'(2));
  assign full_ev    = run && (cnt == last_pos);
  assign half_ev    = run && splittable && (cnt == half_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (run)     cnt <= full_ev ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/baud_phase.sv
module baud_phase #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          full_ev,
  input  logic          half_ev,
  input  logic          both,
  input  logic          split,
  input  logic [RW-1:0] ratio,
  output logic          os_tick,
  output logic          bit_tick,
  output logic          sample_strobe
);
  localparam int HW = RW + 1;

  logic [HW-1:0] pos;
  logic [HW-1:0] step;
  logic [HW-1:0] nxt;
  logic [HW-1:0] span;
  logic [HW-1:0] mid;

  assign span = {ratio, 1'b0};
  assign mid  = {1'b0, ratio};

  // Position in half-ticks: whole-tick steps count 2, half steps count 1.
  always_comb begin
    if (both && split) step = (full_ev || half_ev) ? HW'(1) : '0;
    else               step = full_ev ? HW'(2) : '0;
  end

  assign nxt           = pos + step;
  assign os_tick       = (step != '0);
  assign bit_tick      = os_tick && (nxt >= span);
  assign sample_strobe = os_tick && (pos < mid) && (nxt >= mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos <= '0;
    else if (clear)    pos <= '0;
    else if (bit_tick) pos <= '0;
    else               pos <= nxt;
  end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               resync,
  input  logic [DIV_W-1:0]   div_in,
  input  logic [FIELD_W-1:0] ratio_field,
  input  logic               both_edge_in,
  output logic               os_tick,
  output logic               bit_tick,
  output logic               sample_strobe
);
  logic [DIV_W-1:0]   cfg_div;
  logic [RATIO_W-1:0] cfg_ratio;
  logic               cfg_both;
  logic               div_zero;
  logic               run;
  logic               clear;
  logic               split;
  logic               full_ev;
  logic               half_ev;

  // Shadow configuration, loaded only while the generator is stopped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_div   <= '0;
      cfg_ratio <= RATIO_W'(MIN_RATIO);
      cfg_both  <= 1'b1;
    end else if (!enable) begin
      cfg_div   <= div_in;
      cfg_ratio <= eff_ratio(ratio_field);
      cfg_both  <= eff_both(both_edge_in, eff_ratio(ratio_field));
    end
  end

  assign div_zero = (cfg_div == '0);
  assign clear    = !enable || resync;
  assign run      = enable && !resync && !div_zero;
  assign split    = (cfg_div >= DIV_W'(2));

  baud_prescaler #(.W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .run     (run),
    .div     (cfg_div),
    .full_ev (full_ev),
    .half_ev (half_ev)
  );

  baud_phase #(.RW(RATIO_W)) u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (clear),
    .full_ev       (full_ev),
    .half_ev       (half_ev),
    .both          (cfg_both),
    .split         (split),
    .ratio         (cfg_ratio),
    .os_tick       (os_tick),
    .bit_tick      (bit_tick),
    .sample_strobe (sample_strobe)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk
  import baud_gen_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               resync,
  input logic [DIV_W-1:0]   cfg_div,
  input logic [RATIO_W-1:0] cfg_ratio,
  input logic               os_tick,
  input logic               bit_tick,
  input logic               sample_strobe
);
  localparam int PW = DIV_W + RATIO_W;

  logic [PW-1:0] since;
  logic [PW-1:0] period;

  assign period = PW'(cfg_div) * PW'(cfg_ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            since <= '0;
    else if (!enable || resync || bit_tick) since <= '0;
    else if (cfg_div != '0)                since <= since + PW'(1);
  end

  assert_period_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (since == period - PW'(1)));
  assert_bit_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);
  assert_ratio_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ratio >= RATIO_W'(MIN_RATIO)) && (cfg_ratio <= RATIO_W'(32)));
  assert_zero_div_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_div == '0) |-> !(os_tick || bit_tick || sample_strobe));
  assert_strobe_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> (os_tick && !bit_tick));
  assert_resync_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> !(os_tick || bit_tick || sample_strobe));
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(cfg_div) && $stable(cfg_ratio)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(os_tick || bit_tick || sample_strobe));
endmodule

bind baud_gen baud_gen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .resync        (resync),
  .cfg_div       (cfg_div),
  .cfg_ratio     (cfg_ratio),
  .os_tick       (os_tick),
  .bit_tick      (bit_tick),
  .sample_strobe (sample_strobe)
);

// File: tb/tb_baud_gen.sv
module tb_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        resync = 1'b0;
  logic [12:0] div_in = '0;
  logic [4:0]  ratio_field = '0;
  logic        both_edge_in = 1'b0;
  logic        os_tick, bit_tick, sample_strobe;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  baud_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .resync(resync),
    .div_in(div_in), .ratio_field(ratio_field), .both_edge_in(both_edge_in),
    .os_tick(os_tick), .bit_tick(bit_tick), .sample_strobe(sample_strobe)
  );

  // Expected ratio from the field (R3) and the forced both-edge rule (R6).
  function automatic int ratio_of(int f);
    return (f + 1 < 4) ? 4 : f + 1;
  endfunction

  // Expected {os, bit, strobe} on cycle k of a run (R1, R2, R5, R7).
  function automatic logic [2:0] expect_out(int k, int d, int r, bit be);
    int p, kp, kb, soff;
    logic o, b, s;
    if (d == 0) return 3'b000;
    p  = d * r;
    kp = k % d;
    kb = k % p;
    o  = (kp == d - 1) || (be && d >= 2 && kp == d / 2 - 1);
    b  = (kb == p - 1);
    if (be && d >= 2 && (r % 2) == 1) soff = ((r - 1) / 2) * d + d / 2 - 1;
    else                               soff = ((r + 1) / 2) * d - 1;
    s  = (kb == soff);
    return {o, b, s};
  endfunction

  task automatic check(logic [2:0] exp, string tag);
    compared++;
    if ({os_tick, bit_tick, sample_strobe} !== exp) begin
      mismatched++;
      $display("FAIL %s: got os/bit/smp=%b expected %b at %0t",
               tag, {os_tick, bit_tick, sample_strobe}, exp, $time);
    end
  endtask

  // Load a setting while stopped; check outputs stay quiet (R10).
  task automatic load(int d, int f, bit be);
    @(negedge clk);
    enable = 1'b0; resync = 1'b0;
    div_in = 13'(d); ratio_field = 5'(f); both_edge_in = be;
    #1 check(3'b000, "R10 idle");
    @(negedge clk);
    #1 check(3'b000, "R10 idle");
  endtask

  // Run n cycles. poke: change fields mid-run (R9). rs: resync at n/3 (R8).
  task automatic run_cfg(int d, int f, bit be, int n, bit poke, bit rs, string tag);
    int r, k;
    bit beff;
    r = ratio_of(f);
    beff = be || (r < 8);
    load(d, f, be);
    k = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enable = 1'b1;
      resync = (rs && i == n / 3);
      if (poke && i == n / 2) begin
        div_in = 13'(d + 3); ratio_field = 5'(f ^ 5'h0a); both_edge_in = ~be;
      end
      #1;
      if (resync) begin
        check(3'b000, "R8 resync cycle");
        k = 0;
      end else begin
        check(expect_out(k, d, r, beff), tag);
        k++;
      end
    end
    @(negedge clk);
    resync = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    #1 check(3'b000, "R10 reset state");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(3'b000, "R10 after reset");

    run_cfg(26, 7, 0, 2 * 208 + 5, 0, 0, "R1/R2/R7 26x8");
    run_cfg(1, 31, 1, 70, 0, 0, "R5 divisor one");
    run_cfg(2, 4, 0, 30, 0, 0, "R6/R5/R7 forced both-edge");
    run_cfg(5, 8, 1, 120, 0, 0, "R5/R7 both-edge odd");
    run_cfg(3, 0, 0, 40, 0, 0, "R3 clamped field");
    run_cfg(0, 7, 0, 200, 0, 0, "R4 zero divisor");
    run_cfg(7, 9, 0, 200, 1, 0, "R9 live change ignored");
    run_cfg(9, 11, 0, 300, 0, 1, "R8 after resync");
    run_cfg(8191, 3, 0, 32764 + 10, 0, 0, "R1 max divisor");

    for (int t = 0; t < 24; t++) begin
      int d, f;
      bit be;
      d  = 1 + int'($urandom % 40);
      f  = int'($urandom % 32);
      be = bit'($urandom % 2);
      run_cfg(d, f, be, 2 * d * ratio_of(f) + 3, bit'(t % 3 == 0), bit'(t % 4 == 1),
              "R1/R2/R5/R6/R7 random");
    end

    load(4, 7, 0);
    #1 check(3'b000, "R10 stopped");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule